// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block shifts captured audio samples out on a single serial data line. Up to six channel words are presented in parallel. The line is framed by a bit clock and a frame clock, which come from a clock divider or an external clock provider. Both clocks are sampled in the system clock domain. Every falling bit-clock edge moves the data line to its next bit, MSB first.

Three framings are supported: I2S, left-justified, and TDM. TDM comes in two variants. In one, the first bit is aligned to the frame sync. In the other, it is delayed by one extra bit clock. In TDM the transmit start can be pushed back by a programmable number of bit clocks. This lets several transmitters share one data line, each starting at its own slot boundary. Word length, channel count and offset are static configuration, changed only between frames.

Top module: `aud_serial_tx`

## Requirements
- R1: After reset the data line is low, and it stays low until the first frame start.
- R2: Word length is selected by a two-bit code: 0 → 16, 1 → 20, 2 → 24, 3 → 32 bits. Each channel occupies a 32-bit lane of the sample bus, with channel n at bits [32n+31:32n]. A word is the low word-length bits of its lane, sent MSB first.
- R3: Format code 1 is left-justified. The left channel (lane 0) is sent while the frame clock is high, and the right channel (lane 1) while it is low. The MSB goes out on the first bit-clock fall after a frame-clock transition. Bit clocks of a half-frame beyond the word length carry 0.
- R4: Format code 0 is I2S. The left channel is sent while the frame clock is low. The output is the left-justified stream delayed by one bit clock, so the last bit of a half-frame appears in the first bit clock of the following half.
- R5: Format codes 2 and 3 are TDM. A frame starts at the bit-clock fall where the frame clock is first seen high. Slots follow in lane order 0, 1, 2, ..., each one word long, with no gaps.
- R6: The TDM channel count is selected by a two-bit code: 0 → 2, 1 → 4, 2 → 6. Code 3 is rejected, and the line stays low for the whole frame.
- R7: With TDM code 2, the MSB of slot 0 appears exactly offset bit clocks after the frame start. The offset is an 8-bit value from 0 to 255, and bit clocks before the MSB carry 0.
- R8: TDM code 3 delays the whole TDM stream by one more bit clock than code 2 does for the same offset.
- R9: In TDM, bit clocks after the last active slot carry 0.
- R10: The sample bus is captured at each frame start (left-half start in I2S or left-justified mode). A change of the bus during a frame has no effect until the next frame.
- R11: The data line changes only in the system clock cycle that follows a falling bit-clock edge. It is stable while the bit clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bit and frame clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bck_i | input | 1 | Bit clock |
| lrck_i | input | 1 | Frame clock (half-frame select or TDM sync) |
| fmt_i | input | 2 | Format: 0 I2S, 1 left-justified, 2 TDM, 3 TDM with one-bit delay |
| wlen_sel_i | input | 2 | Word length code |
| tdm_cnt_sel_i | input | 2 | TDM channel count code |
| tdm_off_i | input | 8 | TDM transmit offset in bit clocks |
| samples_i | input | NCH*SW | Parallel channel words, one 32-bit lane per channel |
| sd_o | output | 1 | Serial data output |

## Verification
The bench sweeps every word length in both stereo formats, with half-frames equal to and longer than the word. It targets the I2S wrap, where a design without the one-bit delay register would lose the right-channel LSB or put it in the wrong half. In TDM it sweeps every channel count and both delay variants, with offsets that include 0, one slot width and the maximum of 255. A miscounted offset shifts every slot. A missing saturation leaks data past the last slot. An off-by-one in the delayed variant moves every bit by one clock. A mid-frame bus change checks that a design sampling live data would corrupt the word in flight.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_TDM  = 2'd2,
        FMT_TDMD = 2'd3
    } fmt_e;

    // word length in bits from its two-bit code
    function automatic logic [5:0] wlen_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd16;
            2'd1:    return 6'd20;
            2'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // TDM slot count; the reserved code yields zero slots
    function automatic logic [2:0] tdm_slots(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd2;
            2'd1:    return 3'd4;
            2'd2:    return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/aud_tx_edge.sv
module aud_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_i,
    input  logic lrck_i,
    output logic tick_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic bck;
        logic lrck;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d     = edge_q;
        edge_d.bck = bck_i;
        tick_o     = edge_q.bck && !bck_i;
        rise_o     = tick_o && lrck_i && !edge_q.lrck;
        fall_o     = tick_o && !lrck_i && edge_q.lrck;
        if (tick_o) begin
            edge_d.lrck = lrck_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

endmodule

// File: rtl/aud_tx_seq.sv
module aud_tx_seq
    import aud_tx_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       rise_i,
    input  logic                       fall_i,
    input  logic                       lrck_i,
    input  logic [1:0]                 fmt_i,
    input  logic [1:0]                 wlen_sel_i,
    input  logic [1:0]                 cnt_sel_i,
    input  logic [7:0]                 off_i,
    output logic                       start_o,
    output logic                       active_o,
    output logic [$clog2(NCH+1)-1:0]   slot_o,
    output logic [5:0]                 bit_o
);

    localparam int SLOT_W = $clog2(NCH + 1);

    typedef struct packed {
        logic [8:0]        off;
        logic [SLOT_W-1:0] slot;
        logic [5:0]        bitn;
        logic [SLOT_W-1:0] lim;
    } seq_t;

    seq_t seq_d, seq_q;
    fmt_e fmt;
    logic [5:0] wlen;
    logic is_tdm, left_now, half_start;

    always_comb begin
        fmt        = fmt_e'(fmt_i);
        wlen       = wlen_bits(wlen_sel_i);
        is_tdm     = fmt_i[1];
        left_now   = (fmt == FMT_I2S) ? !lrck_i : lrck_i;
        half_start = tick_i && !is_tdm && (rise_i || fall_i);
        start_o    = is_tdm ? rise_i : (half_start && left_now);
        seq_d      = seq_q;
        if (tick_i) begin
            if (is_tdm && rise_i) begin
                seq_d.off  = {1'b0, off_i} + {8'd0, fmt == FMT_TDMD};
                seq_d.slot = '0;
                seq_d.bitn = '0;
                seq_d.lim  = SLOT_W'(tdm_slots(cnt_sel_i));
            end else if (half_start) begin
                seq_d.off  = '0;
                seq_d.slot = left_now ? SLOT_W'(0) : SLOT_W'(1);
                seq_d.bitn = '0;
                seq_d.lim  = seq_d.slot + SLOT_W'(1);
            end else if (seq_q.off != 9'd0) begin
                seq_d.off = seq_q.off - 9'd1;
            end else if (seq_q.bitn >= wlen - 6'd1) begin
                seq_d.bitn = '0;
                if (seq_q.slot != '1) begin
                    seq_d.slot = seq_q.slot + SLOT_W'(1);
                end
            end else begin
                seq_d.bitn = seq_q.bitn + 6'd1;
            end
        end
        active_o = tick_i && (seq_d.off == 9'd0) && (seq_d.slot < seq_d.lim);
        slot_o   = seq_d.slot;
        bit_o    = seq_d.bitn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // bit counter wraps at the configured word length
    p_bit_in_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (bit_o < wlen_bits(wlen_sel_i)));

    // every stereo half opens with an MSB
    p_half_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !fmt_i[1] && (rise_i || fall_i)) |-> (active_o && bit_o == 6'd0));

    // rejected channel count transmits nothing from the sync on
    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && fmt_i[1] && cnt_sel_i == 2'b11) |-> !active_o);

    // non-zero lead keeps the sync bit silent
    p_lead_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && fmt_i[1] && (off_i != 8'd0 || fmt_i[0])) |-> !active_o);

endmodule

// File: rtl/aud_tx_bitsel.sv
module aud_tx_bitsel
    import aud_tx_pkg::*;
#(
    parameter int NCH = 6,
    parameter int SW  = 32
) (
    input  logic [NCH*SW-1:0]         smp_i,
    input  logic                      active_i,
    input  logic [$clog2(NCH+1)-1:0]  slot_i,
    input  logic [5:0]                bit_i,
    input  logic [1:0]                wlen_sel_i,
    output logic                      bit_o
);

    localparam int IDX_W = $clog2(SW);

    logic [SW-1:0] lane [NCH];
    logic [5:0]    idx;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        assign lane[g] = smp_i[g*SW +: SW];
    end

    always_comb begin
        idx   = wlen_bits(wlen_sel_i) - 6'd1 - bit_i;
        bit_o = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (active_i && slot_i == ($clog2(NCH+1))'(c)) begin
                bit_o = lane[c][idx[IDX_W-1:0]];
            end
        end
    end

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int NCH = 6,
    parameter int SW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bck_i,
    input  logic              lrck_i,
    input  logic [1:0]        fmt_i,
    input  logic [1:0]        wlen_sel_i,
    input  logic [1:0]        tdm_cnt_sel_i,
    input  logic [7:0]        tdm_off_i,
    input  logic [NCH*SW-1:0] samples_i,
    output logic              sd_o
);

    localparam int SLOT_W = $clog2(NCH + 1);

    typedef struct packed {
        logic [NCH*SW-1:0] smp;
        logic              prev;
        logic              sd;
    } tx_t;

    tx_t tx_d, tx_q;
    logic tick, rise, fall, start, active, cur_bit;
    logic [SLOT_W-1:0] slot;
    logic [5:0] bitn;
    logic [NCH*SW-1:0] smp_use;

    aud_tx_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck_i  (bck_i),
        .lrck_i (lrck_i),
        .tick_o (tick),
        .rise_o (rise),
        .fall_o (fall)
    );

    aud_tx_seq #(.NCH(NCH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rise_i     (rise),
        .fall_i     (fall),
        .lrck_i     (lrck_i),
        .fmt_i      (fmt_i),
        .wlen_sel_i (wlen_sel_i),
        .cnt_sel_i  (tdm_cnt_sel_i),
        .off_i      (tdm_off_i),
        .start_o    (start),
        .active_o   (active),
        .slot_o     (slot),
        .bit_o      (bitn)
    );

    aud_tx_bitsel #(.NCH(NCH), .SW(SW)) u_bitsel (
        .smp_i      (smp_use),
        .active_i   (active),
        .slot_i     (slot),
        .bit_i      (bitn),
        .wlen_sel_i (wlen_sel_i),
        .bit_o      (cur_bit)
    );

    always_comb begin
        tx_d    = tx_q;
        smp_use = start ? samples_i : tx_q.smp;
        if (start) begin
            tx_d.smp = samples_i;
        end
        if (tick) begin
            tx_d.prev = cur_bit;
            tx_d.sd   = (fmt_e'(fmt_i) == FMT_I2S) ? tx_q.prev : cur_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sd_o = tx_q.sd;

    // output only moves right after a falling bit-clock edge
    p_sd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bck_i || !$past(bck_i)) |=> $stable(sd_o));

endmodule

// File: tb/aud_serial_tx_bench.sv
module aud_serial_tx_bench;

    localparam int NCH = 6;
    localparam int SW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bck = 1'b1;
    logic lrck = 1'b0;
    logic [1:0] fmt = 2'd1;
    logic [1:0] wsel = 2'd0;
    logic [1:0] nsel = 2'd0;
    logic [7:0] off = 8'd0;
    logic [NCH*SW-1:0] samples = '0;
    logic sd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    aud_serial_tx #(.NCH(NCH), .SW(SW)) u_aud_serial_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .bck_i         (bck),
        .lrck_i        (lrck),
        .fmt_i         (fmt),
        .wlen_sel_i    (wsel),
        .tdm_cnt_sel_i (nsel),
        .tdm_off_i     (off),
        .samples_i     (samples),
        .sd_o          (sd)
    );

    function automatic int wl(input logic [1:0] s);
        case (s)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic int cnt(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 4;
            2'd2: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [NCH*SW-1:0] mk(input int seed);
        logic [NCH*SW-1:0] r;
        for (int c = 0; c < NCH; c++) begin
            r[c*SW +: SW] = (32'(seed) * 32'h9E37_79B9) ^ (32'(c + 1) * 32'h7F4A_7C15) ^ 32'h5A5A_A5C3;
        end
        return r;
    endfunction

    task automatic chk(input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b exp %0b", what, got, exp);
        end
    endtask

    // one bit clock: falling edge with new frame clock, sample at rise and before next fall
    task automatic step(input logic lr, output logic v1, output logic v2);
        bck  = 1'b0;
        lrck = lr;
        repeat (2) @(negedge clk);
        bck = 1'b1;
        v1  = sd;
        repeat (2) @(negedge clk);
        v2  = sd;
    endtask

    task automatic run_stereo(input logic [1:0] f, input logic [1:0] ws, input int h);
        logic v1, v2, e;
        int w, g, c, hp;
        w    = wl(ws);
        fmt  = f;
        wsel = ws;
        for (int i = 0; i < 4; i++) step(f == 2'd0, v1, v2);
        for (int fr = 0; fr < 2; fr++) begin
            for (int k = 0; k < 2 * h; k++) begin
                step((f == 2'd0) ? (k >= h) : (k < h), v1, v2);
                if (fr == 1) begin
                    g  = (f == 2'd0) ? (k + 2 * h - 1) % (2 * h) : k;
                    c  = g / h;
                    hp = g % h;
                    e  = (hp < w) ? samples[c*SW + w - 1 - hp] : 1'b0;
                    if (f == 2'd0)
                        chk($sformatf("R4 R2 i2s w%0d h%0d k%0d", w, h, k), v1, e);
                    else
                        chk($sformatf("R3 R2 lj w%0d h%0d k%0d", w, h, k), v1, e);
                    chk($sformatf("R11 hold k%0d", k), v2, v1);
                end
            end
        end
    endtask

    task automatic run_tdm(input logic [1:0] ws, input logic [1:0] ns, input int o, input bit dl);
        logic v1, v2, e;
        int w, n, t;
        string tag;
        w    = wl(ws);
        n    = cnt(ns);
        fmt  = dl ? 2'd3 : 2'd2;
        wsel = ws;
        nsel = ns;
        off  = 8'(o);
        for (int i = 0; i < 4; i++) step(1'b0, v1, v2);
        for (int k = 0; k < 256; k++) begin
            step(k == 0, v1, v2);
            t = k - o - (dl ? 1 : 0);
            e = (t >= 0 && t < n * w) ? samples[(t / w) * SW + w - 1 - (t % w)] : 1'b0;
            if (ns == 2'd3)      tag = "R6";
            else if (t < 0)      tag = dl ? "R8" : "R7";
            else if (t >= n * w) tag = "R9";
            else                 tag = dl ? "R8" : "R5";
            chk($sformatf("%s tdm w%0d n%0d off%0d k%0d", tag, w, n, o, k), v1, e);
        end
    endtask

    initial begin
        logic v1, v2;
        logic [NCH*SW-1:0] old_s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", sd, 1'b0);
        samples = mk(1);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, v1, v2);
            chk("R1 idle before first frame", v1, 1'b0);
        end

        // stereo sweeps: both formats, all word lengths, tight and long halves
        for (int f = 0; f < 2; f++) begin
            for (int ws = 0; ws < 4; ws++) begin
                samples = mk(10 + f * 4 + ws);
                run_stereo(2'(f), 2'(ws), wl(2'(ws)));
                run_stereo(2'(f), 2'(ws), 32 + 4);
            end
        end

        // R10: mid-frame bus change must not reach the current frame
        fmt = 2'd1;
        wsel = 2'd2;
        old_s = mk(77);
        samples = old_s;
        for (int i = 0; i < 4; i++) step(1'b0, v1, v2);
        for (int k = 0; k < 48; k++) begin
            if (k == 3) samples = mk(78);
            step(k < 24, v1, v2);
            chk($sformatf("R10 old frame k%0d", k), v1, old_s[(k / 24) * SW + 23 - (k % 24)]);
        end
        for (int k = 0; k < 48; k++) begin
            step(k < 24, v1, v2);
            chk($sformatf("R10 new frame k%0d", k), v1, samples[(k / 24) * SW + 23 - (k % 24)]);
        end

        // TDM sweep over word length, channel count and delay variant
        for (int ws = 0; ws < 4; ws++) begin
            for (int ns = 0; ns < 3; ns++) begin
                for (int d = 0; d < 2; d++) begin
                    samples = mk(100 + ws * 8 + ns * 2 + d);
                    run_tdm(2'(ws), 2'(ns), (ws * 37 + ns * 11 + d * 5) % 256, d[0]);
                end
            end
        end
        samples = mk(200);
        run_tdm(2'd3, 2'd2, 0, 1'b0);
        run_tdm(2'd0, 2'd1, 16, 1'b0);
        run_tdm(2'd2, 2'd2, 24, 1'b1);
        run_tdm(2'd0, 2'd0, 255, 1'b0);
        run_tdm(2'd0, 2'd0, 255, 1'b1);
        run_tdm(2'd3, 2'd3, 0, 1'b0);
        run_tdm(2'd1, 2'd3, 9, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule